// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps the contents of a synchronous DRAM alive by asking for auto-refresh commands at a steady rate. The target is that every row is refreshed once in each 64 ms retention window. A cycle timer runs on the memory clock and ends at a terminal count held in a register. Each time it ends, one refresh becomes owed. When at least one refresh is owed, the block raises a request to the command scheduler. The scheduler closes every open bank, honouring the active-to-precharge and precharge times. It then answers with a grant, and in that cycle the refresh command goes out. The memory is then marked busy for a fixed number of cycles, and normal traffic is held off during that time.

The terminal count is the per-row interval for a part with 4096 rows. As an example, 15.6 µs at 100 MHz is 1560 cycles. For parts with 8192 rows, software picks one of two ways to reach all rows in time:
- halve the interval, refreshing one row per command;
- keep the interval and refresh two adjacent rows per command.

The row index counts the rows already serviced and wraps at the configured row count. While the scheduler withholds its grant, up to eight owed refreshes are remembered. Once the grant arrives they are served back to back.

Top module: `refresh_sched`

## Requirements
- R1: While rst_n is low, and in the first cycle after it goes high, ref_req, ref_cmd and busy are 0 and ref_row is 0. The interval timer restarts from zero.
- R2: In 4096-row mode (rows_8k=0), one refresh becomes owed whenever the timer count plus one reaches or exceeds interval_cfg (at least 2). The timer then restarts from zero. The first refresh after reset is therefore owed on the interval_cfg-th rising edge, and ref_req is seen high after that edge.
- R3: In 8192-row mode with dual_row=0, the terminal count is interval_cfg shifted right by one, so refreshes fall due at twice the rate.
- R4: In 8192-row mode with dual_row=1, the terminal count is interval_cfg. Each command advances ref_row by 2, so ref_row stays even.
- R5: ref_cmd is 1 in exactly those cycles where ref_req and grant are both 1. busy is 1 for the 8 cycles that follow a command. ref_req is 0 while busy is 1.
- R6: At most 8 refreshes are counted as owed, and a refresh that falls due with 8 already owed is dropped. Owed refreshes are served back to back: with grant held at 1, successive commands are 9 cycles apart.
- R7: After a command, ref_row becomes (ref_row + step) modulo the row count, where the row count is 4096 when rows_8k=0 and 8192 when rows_8k=1.
- R8: ref_req, once raised, stays 1 until a command is issued. A grant given while ref_req is 0 issues no command and changes nothing.
- R9: ref_row changes only on the edge that follows a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_cfg | input | 16 | Refresh interval in clock cycles for a 4096-row part (at least 2) |
| rows_8k | input | 1 | Row-count mode: 0 = 4096 rows, 1 = 8192 rows |
| dual_row | input | 1 | With 8192 rows: 0 = double the rate, 1 = two rows per command |
| grant | input | 1 | Scheduler grant: all banks are closed and the refresh may go out |
| ref_req | output | 1 | Refresh request, asking for all banks to be closed |
| ref_cmd | output | 1 | Refresh command issued in this cycle |
| ref_row | output | 13 | Index of the first row refreshed by the next command |
| busy | output | 1 | Memory occupied by a refresh; normal traffic is held off |

## Verification
Each output has its own delay after the edge that causes it:
- A due refresh shows on ref_req one cycle after the timer's terminal edge.
- ref_cmd follows grant within the same cycle.
- busy rises on the next edge after a command and falls 8 edges later.
- ref_row moves on the edge after a command.

A behavioural model in the bench updates its counters on the same rising edges as the block. The bench drives new inputs at the falling edge and samples all four outputs one nanosecond later, so each result is compared in the cycle where it is due. Scenarios add explicit checks on top of the model comparison: a backlog drained with command spacing of exactly 9 cycles, all-even rows in two-row mode, and the row index wrapping at 4096 and at 8192.

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched #(
  parameter int TIMER_W  = 16,
  parameter int ROW_W    = 13,
  parameter int OWED_MAX = 8,
  parameter int BUSY_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] interval_cfg,
  input  logic               rows_8k,
  input  logic               dual_row,
  input  logic               grant,
  output logic               ref_req,
  output logic               ref_cmd,
  output logic [ROW_W-1:0]   ref_row,
  output logic               busy
);
  localparam int OWED_W = $clog2(OWED_MAX + 1);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] term;
  logic [OWED_W-1:0]  owed;
  logic [BUSY_W-1:0]  bcnt;
  logic [ROW_W-1:0]   row;
  logic [ROW_W-1:0]   row_mask;
  logic [ROW_W-1:0]   row_step;
  logic               tick;

  assign term     = (rows_8k && !dual_row) ? (interval_cfg >> 1) : interval_cfg;
  assign tick     = ({1'b0, timer} + 1'b1) >= {1'b0, term};
  assign row_mask = rows_8k ? {ROW_W{1'b1}} : {1'b0, {(ROW_W-1){1'b1}}};
  assign row_step = (rows_8k && dual_row) ? ROW_W'(2) : ROW_W'(1);

  assign busy    = bcnt != '0;
  assign ref_req = (owed != '0) && !busy;
  assign ref_cmd = ref_req && grant;
  assign ref_row = row;

  always_ff @(posedge clk) begin
    if (!rst_n) timer <= '0;
    else if (tick) timer <= '0;
    else timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else if (tick && !ref_cmd) begin
      if (owed != OWED_W'(OWED_MAX)) owed <= owed + 1'b1;
    end else if (!tick && ref_cmd) owed <= owed - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (ref_cmd) bcnt <= BUSY_W'(BUSY_CYC);
    else if (bcnt != '0) bcnt <= bcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) row <= '0;
    else if (ref_cmd) row <= (row + row_step) & row_mask;
  end

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OWED_W'(OWED_MAX));                                           // R6
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ref_req);                                                   // R5
  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |=> busy);                                                    // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !grant) |=> ref_req);                                     // R8
  AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_cmd |=> $stable(ref_row));                                       // R9
  AST_ROW_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rows_8k && dual_row && !ref_row[0] && ref_cmd) |=> !ref_row[0]);     // R4
endmodule

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] interval_cfg = 16'd20;
  logic        rows_8k = 0;
  logic        dual_row = 0;
  logic        grant = 0;
  logic        ref_req, ref_cmd, busy;
  logic [12:0] ref_row;

  int checks = 0;
  int errors = 0;
  int m_timer = 0, m_owed = 0, m_row = 0, m_bcnt = 0;
  int ncmd = 0;
  bit in_reset = 1;

  always #2.5 clk = ~clk;

  refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .interval_cfg(interval_cfg),
    .rows_8k(rows_8k), .dual_row(dual_row), .grant(grant),
    .ref_req(ref_req), .ref_cmd(ref_cmd), .ref_row(ref_row), .busy(busy)
  );

  always @(posedge clk) begin
    int tc, step, rows;
    bit tick, issue;
    if (!rst_n) begin
      m_timer = 0; m_owed = 0; m_row = 0; m_bcnt = 0;
    end else begin
      tc    = (rows_8k && !dual_row) ? (interval_cfg / 2) : interval_cfg;
      tick  = (m_timer + 1) >= tc;
      issue = (m_owed > 0) && (m_bcnt == 0) && grant;
      step  = (rows_8k && dual_row) ? 2 : 1;
      rows  = rows_8k ? 8192 : 4096;
      m_timer = tick ? 0 : m_timer + 1;
      if (tick && !issue && m_owed < 8) m_owed++;
      else if (!tick && issue) m_owed--;
      if (issue) m_row = (m_row + step) % rows;
      m_bcnt = issue ? 8 : (m_bcnt > 0 ? m_bcnt - 1 : 0);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic g);
    bit er, ec, eb;
    @(negedge clk);
    grant = g;
    #1;
    er = (m_owed > 0) && (m_bcnt == 0);
    ec = er && g;
    eb = m_bcnt > 0;
    check(ref_req == er, in_reset ? "R1 ref_req" : "R2 ref_req", ref_req, er);
    check(ref_cmd == ec, in_reset ? "R1 ref_cmd" : "R8 ref_cmd", ref_cmd, ec);
    check(busy == eb, in_reset ? "R1 busy" : "R5 busy", busy, eb);
    check(ref_row == m_row, in_reset ? "R1 ref_row" : "R9 ref_row", ref_row, m_row);
    if (ref_cmd) ncmd++;
  endtask

  task automatic do_reset(input bit m8k, input bit dual, input int ivl);
    @(negedge clk);
    rst_n = 0; grant = 0; in_reset = 1;
    rows_8k = m8k; dual_row = dual; interval_cfg = 16'(ivl);
    repeat (3) step(0);
    rst_n = 1;
    step(0);
    in_reset = 0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    int first;
    bit wrapped, odd;
    int prev;

    do_reset(0, 0, 20);
    check(ref_req == 0 && busy == 0 && ref_row == 0, "R1 reset state", ref_req, 0);

    // R8: grant with nothing owed; R2: first request after the 20th edge
    first = -1;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (ref_cmd && first < 0) first = i;
    end
    check(first == 18, "R2 first command cycle", first, 18);

    // R5: command spacing with grant delayed
    repeat (200) step(($urandom % 3) == 0);

    // R6: backlog saturates, then drains back to back
    do_reset(0, 0, 20);
    repeat (300) step(0);
    ncmd = 0;
    for (int i = 0; i < 72; i++) step(1);
    check(ncmd == 8, "R6 backlog drained in 72 cycles", ncmd, 8);
    repeat (100) step(1);

    // R3: double rate
    do_reset(1, 0, 40);
    ncmd = 0;
    for (int i = 0; i < 400; i++) step(1);
    check(ncmd == 20, "R3 commands in 400 cycles", ncmd, 20);

    // R4: two rows per command
    do_reset(1, 1, 20);
    odd = 0;
    for (int i = 0; i < 400; i++) begin
      step(i % 2);
      if (ref_row[0]) odd = 1;
    end
    check(odd == 0, "R4 rows stay even", odd, 0);

    // R7: wrap at 4096
    do_reset(0, 0, 2);
    wrapped = 0; prev = 0;
    for (int i = 0; i < 4096 * 9 + 40; i++) begin
      step(1);
      if (prev == 4095 && ref_row == 0) wrapped = 1;
      prev = ref_row;
    end
    check(wrapped == 1, "R7 wrap at 4096", wrapped, 1);

    // R7: wrap at 8192 with two rows per command
    do_reset(1, 1, 2);
    wrapped = 0; prev = 0; seen = 0;
    for (int i = 0; i < 4096 * 9 + 40; i++) begin
      step(1);
      if (prev == 8190 && ref_row == 0) wrapped = 1;
      if (ref_row > 4095) seen = 1;
      prev = ref_row;
    end
    check(wrapped == 1 && seen == 1, "R7 wrap at 8192", wrapped, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule